// File: doc/BRIEF.md
# Banked Byte-Serial Address Generator

This block forms the 16-bit virtual address of a load or store one byte at a time. An access starts with a start strobe. In the same cycle the block receives the dynamic-offset flag, a 2-bit base-register select, an 8-bit accumulator offset and the low byte of a 16-bit little-endian immediate. The high immediate byte follows on the same byte input in the next cycle. The block adds the immediate, the selected base register and, when the flag is set, the accumulator offset.

The carry of the low immediate-plus-register sum goes into the high byte. A separate offset adder adds the accumulator to the low byte. A carry out of that adder increments the high byte one cycle later. The result leaves the block as a low byte and then a high byte on one byte output, marked by a valid strobe and a high-byte flag.

The block holds user and kernel copies of the frame and stack pointers, and the privilege input picks the copy. It also holds an index pair made of two byte registers. Kernel software loads the frame and stack copies through a write port, and either mode may load the index pair.

Top module: `vaddr_gen`

## Requirements
- R1: Base select codes: 0 adds nothing, 1 adds the frame pointer, 2 adds the stack pointer, and 3 adds the index pair, where rx is the low byte and ry is the high byte.
- R2: The address equals immediate plus selected base, plus the accumulator offset when dyn_en was 1 at the start edge. With dyn_en at 0 the offset value has no effect.
- R3: Start is sampled with the low immediate byte at edge N, and the high immediate byte is sampled at edge N+1. After edge N+1 the low address byte shows with addr_valid=1 and addr_hi=0. After edge N+2 the high address byte shows with addr_valid=1 and addr_hi=1. In every other cycle addr_valid is 0.
- R4: A carry out of the low immediate-plus-register sum adds one to the high byte.
- R5: A carry out of adding the accumulator offset to the low byte adds one to the high byte.
- R6: Frame and stack reads use the kernel copy when kernel_mode is 1 at the start edge and the user copy otherwise. A mode change takes effect on the very next start.
- R7: A write with wr_en=1 acts on the code in wr_sel. Code 0 loads the frame pointer and code 1 loads the stack pointer, in the copy named by wr_bank (1 is kernel). Code 2 loads rx from wr_data[7:0] and ry from wr_data[15:8] in either mode. Code 3 has no effect. A write is visible to the next start.
- R8: Frame and stack writes made while kernel_mode is 0 leave both copies unchanged.
- R9: The address wraps modulo 65536, and the final carry out is discarded.
- R10: A start during the cycle that carries the high immediate byte is ignored. A new start may be given in the cycle the high address byte is being formed, which gives one address every two cycles.
- R11: Reset clears addr_valid and sets every base register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_mode | input | 1 | 1 selects the kernel privilege mode |
| start | input | 1 | Begins an address computation |
| dyn_en | input | 1 | Adds the accumulator offset |
| base_sel | input | 2 | Base register select |
| acc_off | input | 8 | Accumulator offset |
| imm_byte | input | 8 | Low immediate byte with start, then the high byte one cycle later |
| wr_en | input | 1 | Base register write strobe |
| wr_sel | input | 2 | Write target code |
| wr_bank | input | 1 | Target copy for frame/stack writes, 1 is kernel |
| wr_data | input | 16 | Write data |
| addr_byte | output | 8 | Address byte |
| addr_valid | output | 1 | addr_byte holds a result byte |
| addr_hi | output | 1 | addr_byte is the high byte |

## Verification
For a start sampled at edge N, the low address byte is due after edge N+2 of the bench's edge count, counting the start edge as N+1. The high byte is due one edge after the low byte. The bench records both expected bytes in a per-cycle schedule when it drives the start. On each falling edge it compares valid, the high flag and the byte against the schedule entry for that cycle, and an empty entry means valid must be low. Register writes update the reference model before the start that reads them. This keeps banked, ignored and wrapped cases in step with the cycle in which the design samples them.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;

  typedef enum logic [1:0] {
    BASE_NONE  = 2'd0,
    BASE_FRAME = 2'd1,
    BASE_STACK = 2'd2,
    BASE_INDEX = 2'd3
  } base_sel_e;

  typedef enum logic [1:0] {
    WR_FRAME = 2'd0,
    WR_STACK = 2'd1,
    WR_INDEX = 2'd2,
    WR_NONE  = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HI_IMM = 2'd1,
    ST_HI_OUT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/vaddr_byte_add.sv
module vaddr_byte_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

endmodule

// File: rtl/vaddr_regfile.sv
module vaddr_regfile
  import vaddr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  kernel_mode,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic                  wr_bank,
  input  logic [2*BYTE_W-1:0]   wr_data,
  input  logic [1:0]            rd_sel,
  output logic [2*BYTE_W-1:0]   rd_base
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int NBANK  = 2;

  wr_sel_e   wr_e;
  base_sel_e rd_e;
  assign wr_e = wr_sel_e'(wr_sel);
  assign rd_e = base_sel_e'(rd_sel);

  logic [NBANK-1:0][WORD_W-1:0] frame_all;
  logic [NBANK-1:0][WORD_W-1:0] stack_all;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [WORD_W-1:0] frame_q, frame_d, stack_q, stack_d;
    logic              hit;

    assign hit = wr_en && kernel_mode && (wr_bank == 1'(b));

    always_comb begin
      frame_d = frame_q;
      stack_d = stack_q;
      if (hit && wr_e == WR_FRAME) frame_d = wr_data;
      if (hit && wr_e == WR_STACK) stack_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_q <= '0;
        stack_q <= '0;
      end else begin
        frame_q <= frame_d;
        stack_q <= stack_d;
      end
    end

    assign frame_all[b] = frame_q;
    assign stack_all[b] = stack_q;
  end

  logic [BYTE_W-1:0] rx_q, rx_d, ry_q, ry_d;

  always_comb begin
    rx_d = rx_q;
    ry_d = ry_q;
    if (wr_en && wr_e == WR_INDEX) begin
      rx_d = wr_data[BYTE_W-1:0];
      ry_d = wr_data[WORD_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      ry_q <= '0;
    end else begin
      rx_q <= rx_d;
      ry_q <= ry_d;
    end
  end

  always_comb begin
    unique case (rd_e)
      BASE_FRAME: rd_base = frame_all[kernel_mode];
      BASE_STACK: rd_base = stack_all[kernel_mode];
      BASE_INDEX: rd_base = {ry_q, rx_q};
      default:    rd_base = '0;
    endcase
  end

  // R8: user-mode frame/stack writes leave every copy untouched
  p_user_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !kernel_mode && (wr_e == WR_FRAME || wr_e == WR_STACK))
      |=> ($stable(frame_all) && $stable(stack_all)));

  // R7: index pair takes the written word on the next cycle
  p_idx_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_e == WR_INDEX) |=> ({ry_q, rx_q} == $past(wr_data)));

endmodule

// File: rtl/vaddr_seq.sv
module vaddr_seq
  import vaddr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic take_lo,
  output logic take_hi,
  output logic emit_hi
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_HI_IMM;
      ST_HI_IMM: state_d = ST_HI_OUT;
      ST_HI_OUT: state_d = start ? ST_HI_IMM : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign take_lo = start && (state_q != ST_HI_IMM);
  assign take_hi = (state_q == ST_HI_IMM);
  assign emit_hi = (state_q == ST_HI_OUT);

  // R10: a start in the high-immediate cycle does not restart the sequence
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HI_IMM) |=> (state_q == ST_HI_OUT));

endmodule

// File: rtl/vaddr_gen.sv
module vaddr_gen
  import vaddr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kernel_mode,
  input  logic                start,
  input  logic                dyn_en,
  input  logic [1:0]          base_sel,
  input  logic [BYTE_W-1:0]   acc_off,
  input  logic [BYTE_W-1:0]   imm_byte,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic                wr_bank,
  input  logic [2*BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0]   addr_byte,
  output logic                addr_valid,
  output logic                addr_hi
);

  localparam int WORD_W = 2 * BYTE_W;

  logic              take_lo, take_hi, emit_hi;
  logic [WORD_W-1:0] base_word;

  vaddr_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .take_lo (take_lo),
    .take_hi (take_hi),
    .emit_hi (emit_hi)
  );

  vaddr_regfile #(.BYTE_W(BYTE_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .kernel_mode (kernel_mode),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_bank     (wr_bank),
    .wr_data     (wr_data),
    .rd_sel      (base_sel),
    .rd_base     (base_word)
  );

  // stage registers
  logic [BYTE_W-1:0] lo_q, lo_d, bhi_q, bhi_d, acc_q, acc_d;
  logic              ca_q, ca_d;
  logic [BYTE_W-1:0] hint_q, hint_d, out_q, out_d;
  logic              cd_q, cd_d;
  logic              valid_q, valid_d, hi_q, hi_d;

  logic [BYTE_W-1:0] lo_sum, dyn_sum, hi_sum, inc_sum;
  logic              lo_cy, dyn_cy;

  vaddr_byte_add #(.W(BYTE_W)) u_add_lo (
    .a    (imm_byte),
    .b    (base_word[BYTE_W-1:0]),
    .cin  (1'b0),
    .sum  (lo_sum),
    .cout (lo_cy)
  );

  vaddr_byte_add #(.W(BYTE_W)) u_add_dyn (
    .a    (lo_q),
    .b    (acc_q),
    .cin  (1'b0),
    .sum  (dyn_sum),
    .cout (dyn_cy)
  );

  // high byte: carry out wraps away (modulo address space)
  assign hi_sum  = imm_byte + bhi_q + {{(BYTE_W-1){1'b0}}, ca_q};
  assign inc_sum = hint_q + {{(BYTE_W-1){1'b0}}, cd_q};

  always_comb begin
    lo_d   = lo_q;
    ca_d   = ca_q;
    bhi_d  = bhi_q;
    acc_d  = acc_q;
    hint_d = hint_q;
    cd_d   = cd_q;
    out_d  = out_q;
    if (take_lo) begin
      lo_d  = lo_sum;
      ca_d  = lo_cy;
      bhi_d = base_word[WORD_W-1:BYTE_W];
      acc_d = dyn_en ? acc_off : '0;
    end
    if (take_hi) begin
      out_d  = dyn_sum;
      cd_d   = dyn_cy;
      hint_d = hi_sum;
    end else if (emit_hi) begin
      out_d = inc_sum;
    end
    valid_d = take_hi | emit_hi;
    hi_d    = emit_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      ca_q    <= 1'b0;
      bhi_q   <= '0;
      acc_q   <= '0;
      hint_q  <= '0;
      cd_q    <= 1'b0;
      out_q   <= '0;
      valid_q <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      lo_q    <= lo_d;
      ca_q    <= ca_d;
      bhi_q   <= bhi_d;
      acc_q   <= acc_d;
      hint_q  <= hint_d;
      cd_q    <= cd_d;
      out_q   <= out_d;
      valid_q <= valid_d;
      hi_q    <= hi_d;
    end
  end

  assign addr_byte  = out_q;
  assign addr_valid = valid_q;
  assign addr_hi    = hi_q;

  // R3: a low byte is always followed by its high byte
  p_lo_then_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_hi) |=> (addr_valid && addr_hi));

  // R3: a high byte is always preceded by a low byte
  p_hi_has_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_hi) |-> $past(addr_valid && !addr_hi));

  // R3: the high immediate cycle yields a low byte next
  p_hiimm_gives_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_hi |=> (addr_valid && !addr_hi));

endmodule

// File: tb/vaddr_gen_test.sv
`timescale 1ns/1ps
module vaddr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        kernel_mode, start, dyn_en, wr_en, wr_bank;
  logic [1:0]  base_sel, wr_sel;
  logic [7:0]  acc_off, imm_byte;
  logic [15:0] wr_data;
  logic [7:0]  addr_byte;
  logic        addr_valid, addr_hi;

  always #2.5 clk = ~clk;

  vaddr_gen uut (
    .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .start(start),
    .dyn_en(dyn_en), .base_sel(base_sel), .acc_off(acc_off), .imm_byte(imm_byte),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_bank(wr_bank), .wr_data(wr_data),
    .addr_byte(addr_byte), .addr_valid(addr_valid), .addr_hi(addr_hi)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle expectation schedule
  bit         sv[16];
  bit         sh[16];
  logic [7:0] sb[16];
  string      st[16];

  // reference model state
  logic [15:0] m_frame[2];
  logic [15:0] m_stack[2];
  logic [7:0]  m_rx, m_ry;
  bit          m_kernel;

  function automatic logic [15:0] model_addr(bit dyn, logic [1:0] sel,
                                             logic [7:0] acc, logic [15:0] imm);
    logic [15:0] base;
    case (sel)
      2'd1:    base = m_frame[m_kernel];
      2'd2:    base = m_stack[m_kernel];
      2'd3:    base = {m_ry, m_rx};
      default: base = 16'h0000;
    endcase
    return imm + base + (dyn ? {8'h00, acc} : 16'h0000);
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        checks++;
        if (addr_valid !== 1'b0) begin
          errors++;
          $display("FAIL R11 reset: valid=%b expected 0", addr_valid);
        end
      end else begin
        int i;
        i = cyc % 16;
        checks++;
        if (addr_valid !== sv[i] ||
            (sv[i] && (addr_hi !== sh[i] || addr_byte !== sb[i]))) begin
          errors++;
          $display("FAIL %s cyc %0d: valid=%b hi=%b byte=%h expected valid=%b hi=%b byte=%h",
                   st[i], cyc, addr_valid, addr_hi, addr_byte, sv[i], sh[i], sb[i]);
        end
        sv[i] = 1'b0;
        st[i] = "R3";
      end
    end
  end

  task automatic issue(bit dyn, logic [1:0] sel, logic [7:0] acc,
                       logic [15:0] imm, string tag, bit poke);
    logic [15:0] a;
    int n;
    @(negedge clk);
    kernel_mode = m_kernel;
    start = 1'b1; dyn_en = dyn; base_sel = sel; acc_off = acc; imm_byte = imm[7:0];
    a = model_addr(dyn, sel, acc, imm);
    n = cyc;
    sv[(n+2)%16] = 1'b1; sh[(n+2)%16] = 1'b0; sb[(n+2)%16] = a[7:0];  st[(n+2)%16] = tag;
    sv[(n+3)%16] = 1'b1; sh[(n+3)%16] = 1'b1; sb[(n+3)%16] = a[15:8]; st[(n+3)%16] = tag;
    @(negedge clk);
    start = poke;
    if (poke) begin
      dyn_en = 1'b1; base_sel = 2'd3; acc_off = 8'h55;
    end
    imm_byte = imm[15:8];
  endtask

  task automatic gap(int k);
    @(negedge clk);
    start = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, bit bank, logic [15:0] d);
    @(negedge clk);
    kernel_mode = m_kernel;
    start = 1'b0;
    wr_en = 1'b1; wr_sel = sel; wr_bank = bank; wr_data = d;
    if (sel == 2'd2) {m_ry, m_rx} = d;
    else if (sel == 2'd0 && m_kernel) m_frame[bank] = d;
    else if (sel == 2'd1 && m_kernel) m_stack[bank] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) st[i] = "R3";
    for (int b = 0; b < 2; b++) begin
      m_frame[b] = 16'h0; m_stack[b] = 16'h0;
    end
    m_rx = 8'h0; m_ry = 8'h0; m_kernel = 1'b0;
    rst_n = 1'b0; kernel_mode = 1'b0; start = 1'b0; dyn_en = 1'b0;
    base_sel = 2'd0; acc_off = 8'h0; imm_byte = 8'h0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_bank = 1'b0; wr_data = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gap(2);

    // R11: base registers are zero after reset, both modes
    issue(0, 2'd1, 8'h00, 16'h4321, "R11", 0); gap(2);
    m_kernel = 1'b1;
    issue(0, 2'd2, 8'h00, 16'h0ABC, "R11", 0); gap(2);
    issue(0, 2'd3, 8'h00, 16'h7001, "R11", 0); gap(2);

    // R1: select code 0 adds nothing
    issue(0, 2'd0, 8'h00, 16'h1234, "R1", 0); gap(2);

    // R7: load all copies from kernel mode
    wr(2'd0, 1'b1, 16'h2000);
    wr(2'd0, 1'b0, 16'h1000);
    wr(2'd1, 1'b1, 16'h3F00);
    wr(2'd1, 1'b0, 16'h0F80);
    wr(2'd2, 1'b0, 16'hABCD);
    wr(2'd3, 1'b1, 16'hFFFF);
    issue(0, 2'd3, 8'h00, 16'h0001, "R7", 0); gap(2);
    issue(0, 2'd1, 8'h00, 16'h0010, "R7", 0); gap(2);

    // R6: same access in user then kernel mode, switched on the start cycle
    m_kernel = 1'b0;
    issue(0, 2'd1, 8'h00, 16'h0010, "R6", 0); gap(2);
    m_kernel = 1'b1;
    issue(0, 2'd2, 8'h00, 16'h0044, "R6", 0);
    m_kernel = 1'b0;
    issue(0, 2'd2, 8'h00, 16'h0044, "R6", 0); gap(2);

    // R4: low-byte carry into high byte (0x0F80 + 0x0090)
    issue(0, 2'd2, 8'h00, 16'h0090, "R4", 0); gap(2);

    // R5: offset carry increments high byte
    issue(1, 2'd0, 8'hF0, 16'h0120, "R5", 0); gap(2);
    issue(1, 2'd3, 8'h40, 16'h00F0, "R5", 0); gap(2);

    // R2: offset ignored when flag clear; full sum with flag set
    issue(0, 2'd1, 8'hFF, 16'h0203, "R2", 0); gap(2);
    issue(1, 2'd1, 8'h21, 16'h0203, "R2", 0); gap(2);

    // R9: wrap modulo 65536
    issue(0, 2'd3, 8'h00, 16'h6000, "R9", 0); gap(2);
    issue(1, 2'd0, 8'h01, 16'hFFFF, "R9", 0); gap(2);

    // R8: user-mode frame/stack writes ignored
    m_kernel = 1'b0;
    wr(2'd0, 1'b1, 16'h5555);
    wr(2'd1, 1'b0, 16'h6666);
    issue(0, 2'd2, 8'h00, 16'h0001, "R8", 0); gap(2);
    m_kernel = 1'b1;
    issue(0, 2'd1, 8'h00, 16'h0001, "R8", 0); gap(2);

    // R10: start in the high-immediate cycle ignored; back-to-back stream
    issue(0, 2'd1, 8'h00, 16'h0100, "R10", 1); gap(3);
    issue(1, 2'd3, 8'h33, 16'h1111, "R10", 0);
    issue(0, 2'd2, 8'h00, 16'h2222, "R10", 0);
    issue(1, 2'd0, 8'h99, 16'h3377, "R10", 0);
    gap(5);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule